// File: doc/BRIEF.md
# Twelve-Bit Coefficient Byte Packer

This block turns polynomials of 256 twelve-bit coefficients into a byte stream, writing one byte per clock. Each coefficient is already reduced below 3329. A pulse on `start` captures the polynomial count `k` (2, 3 or 4). The block then walks polynomials 0 to 2k-1 in order and reads each coefficient through a combinational read port.

Every pair of neighbouring coefficients becomes three bytes. The bytes go to one of two byte regions, selected by `wr_sel`. Polynomials 0 to k-1 fill region 0 and polynomials k to 2k-1 fill region 1. After the last polynomial, a 32-byte seed is appended to the end of region 0. A one-cycle `done` pulse closes the run.

The block fits between a coefficient store and two byte memories. It drives the write port directly, and that port needs no handshake.

Top module: `coef_pack12`

## Requirements
- R1: For a pair with c0 at an even coefficient index and c1 at the next odd index, the three bytes written are c0[7:0], then {c1[3:0], c0[11:8]}, then c1[11:4].
- R2: Within its region, pair n of local polynomial p is written at byte addresses p*384+3n, +1 and +2, in that order, on three consecutive write cycles.
- R3: While a run is active, exactly one byte is written every clock with no gaps, for 768*k+32 writes in total. `wr_en` is low on every other cycle.
- R4: Polynomials 0..k-1 are written with `wr_sel`=0 and polynomials k..2k-1 with `wr_sel`=1, re-indexed from local polynomial 0. No region-1 address reaches 384*k.
- R5: After all polynomials, seed byte r (`seed[8r+7:8r]`) is written with `wr_sel`=0 at address 384*k+r, for r = 0 to 31 in ascending order. The last byte of the run is seed byte 31 at 384*k+31.
- R6: `k_sel` is captured only when `start` is seen while idle. A `start` pulse during a run, with any `k_sel`, changes nothing in that run.
- R7: `busy` is high from the cycle after an accepted `start`. `done` is high for exactly one cycle, and that cycle immediately follows the cycle that shows the final seed write. `busy` is low during the `done` cycle.
- R8: `coef_addr` is {polynomial index (3 bits), pair index (7 bits), odd bit}. Data returned in the same cycle is used, and the resulting byte appears on the write port one cycle later.
- R9: While reset is asserted and after its release, `busy`, `done` and `wr_en` are low until a `start` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| k_sel | input | 3 | Polynomial count per region, 2..4 |
| seed | input | 256 | Seed bytes appended to region 0, byte r at bits 8r+7:8r |
| coef_addr | output | 11 | Coefficient read address {poly, pair, odd} |
| coef_data | input | 12 | Coefficient read data for coef_addr, same cycle |
| wr_en | output | 1 | Byte write strobe |
| wr_sel | output | 1 | Target region: 0 first, 1 second |
| wr_addr | output | 11 | Byte address within the region |
| wr_data | output | 8 | Byte value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The following are checked on every cycle:
- the pack/seed phases map one-to-one onto write strobes one cycle later;
- the sub-counter never leaves 0..2;
- the captured `k` never moves during a run;
- region addresses stay inside their bounds;
- `done` is a single pulse that follows a write.

The exact byte values, the nibble interleave, the seed ordering and the mid-run `start` being ignored can only be shown by the bench. It sweeps every k against an arithmetic coefficient pattern and compares every byte of both regions.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PACK = 2'd1,
    PH_SEED = 2'd2,
    PH_FIN  = 2'd3
  } phase_t;
endpackage

// File: rtl/cpk_seq.sv
// Run sequencer: polynomial, pair and sub-byte counters, then the seed tail.
module cpk_seq
  import cpk_pkg::*;
#(
  parameter int N_COEF     = 256,
  parameter int SEED_BYTES = 32,
  parameter int KW         = 3,
  parameter int POLY_W     = 3,
  parameter int PAIR_W     = 7,
  parameter int SEED_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [KW-1:0]     k_sel,
  output phase_t            phase,
  output logic [KW-1:0]     k_q,
  output logic [POLY_W-1:0] poly,
  output logic [PAIR_W-1:0] pair,
  output logic [1:0]        sub,
  output logic [SEED_W-1:0] seed_idx,
  output logic              done
);
  localparam int LAST_PAIR = N_COEF/2 - 1;

  logic [POLY_W:0] last_poly;
  assign last_poly = (POLY_W+1)'({k_q, 1'b0}) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      k_q      <= '0;
      poly     <= '0;
      pair     <= '0;
      sub      <= '0;
      seed_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          k_q   <= k_sel;
          poly  <= '0;
          pair  <= '0;
          sub   <= '0;
          phase <= PH_PACK;
        end
        PH_PACK: begin
          if (sub == 2'd2) begin
            sub <= '0;
            if (pair == PAIR_W'(LAST_PAIR)) begin
              pair <= '0;
              if ({1'b0, poly} == last_poly) begin
                seed_idx <= '0;
                phase    <= PH_SEED;
              end else begin
                poly <= poly + 1'b1;
              end
            end else begin
              pair <= pair + 1'b1;
            end
          end else begin
            sub <= sub + 2'd1;
          end
        end
        PH_SEED: begin
          if (seed_idx == SEED_W'(SEED_BYTES-1)) phase <= PH_FIN;
          else seed_idx <= seed_idx + 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  // R2: sub-byte counter only takes the values 0, 1, 2
  p_sub_range_r2: assert property (@(posedge clk) disable iff (rst)
    sub != 2'd3);

  // R6: captured k holds for the whole run
  p_k_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(k_q));
endmodule

// File: rtl/cpk_pack.sv
// Byte former: nibble interleave, region address, seed tail, registered write port.
module cpk_pack
  import cpk_pkg::*;
#(
  parameter int N_COEF     = 256,
  parameter int SEED_BYTES = 32,
  parameter int KW         = 3,
  parameter int POLY_W     = 3,
  parameter int PAIR_W     = 7,
  parameter int SEED_W     = 5,
  parameter int AW         = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  phase_t                  phase,
  input  logic [KW-1:0]           k_q,
  input  logic [POLY_W-1:0]       poly,
  input  logic [PAIR_W-1:0]       pair,
  input  logic [1:0]              sub,
  input  logic [SEED_W-1:0]       seed_idx,
  input  logic [11:0]             coef_data,
  input  logic [8*SEED_BYTES-1:0] seed,
  output logic                    wr_en,
  output logic                    wr_sel,
  output logic [AW-1:0]           wr_addr,
  output logic [7:0]              wr_data
);
  localparam int BPP = (N_COEF/2)*3;

  logic [3:0]      hold_nib;
  logic [POLY_W:0] kx, lpoly;
  logic            in_r1;
  logic [AW-1:0]   pack_addr, seed_addr;
  logic [7:0]      pack_byte;

  always_comb begin
    kx        = (POLY_W+1)'(k_q);
    in_r1     = ({1'b0, poly} >= kx);
    lpoly     = in_r1 ? ({1'b0, poly} - kx) : {1'b0, poly};
    pack_addr = AW'(lpoly) * AW'(BPP) + AW'(pair) * AW'(3) + AW'(sub);
    seed_addr = AW'(k_q) * AW'(BPP) + AW'(seed_idx);
    case (sub)
      2'd0:    pack_byte = coef_data[7:0];
      2'd1:    pack_byte = {coef_data[3:0], hold_nib};
      default: pack_byte = coef_data[11:4];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_nib <= '0;
      wr_en    <= 1'b0;
      wr_sel   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (phase == PH_PACK) begin
        if (sub == 2'd0) hold_nib <= coef_data[11:8];
        wr_en   <= 1'b1;
        wr_sel  <= in_r1;
        wr_addr <= pack_addr;
        wr_data <= pack_byte;
      end else if (phase == PH_SEED) begin
        wr_en   <= 1'b1;
        wr_sel  <= 1'b0;
        wr_addr <= seed_addr;
        wr_data <= seed[seed_idx*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/coef_pack12.sv
module coef_pack12
  import cpk_pkg::*;
#(
  parameter int KMAX       = 4,
  parameter int N_COEF     = 256,
  parameter int SEED_BYTES = 32,
  localparam int KW     = $clog2(KMAX+1),
  localparam int POLY_W = $clog2(2*KMAX),
  localparam int PAIR_W = $clog2(N_COEF/2),
  localparam int SEED_W = $clog2(SEED_BYTES),
  localparam int BPP    = (N_COEF/2)*3,
  localparam int AW     = $clog2(BPP*KMAX + SEED_BYTES),
  localparam int CAW    = POLY_W + PAIR_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [KW-1:0]           k_sel,
  input  logic [8*SEED_BYTES-1:0] seed,
  output logic [CAW-1:0]          coef_addr,
  input  logic [11:0]             coef_data,
  output logic                    wr_en,
  output logic                    wr_sel,
  output logic [AW-1:0]           wr_addr,
  output logic [7:0]              wr_data,
  output logic                    busy,
  output logic                    done
);
  phase_t            phase;
  logic [KW-1:0]     k_q;
  logic [POLY_W-1:0] poly;
  logic [PAIR_W-1:0] pair;
  logic [1:0]        sub;
  logic [SEED_W-1:0] seed_idx;

  cpk_seq #(
    .N_COEF(N_COEF), .SEED_BYTES(SEED_BYTES), .KW(KW),
    .POLY_W(POLY_W), .PAIR_W(PAIR_W), .SEED_W(SEED_W)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .k_sel(k_sel),
    .phase(phase), .k_q(k_q), .poly(poly), .pair(pair), .sub(sub),
    .seed_idx(seed_idx), .done(done)
  );

  cpk_pack #(
    .N_COEF(N_COEF), .SEED_BYTES(SEED_BYTES), .KW(KW),
    .POLY_W(POLY_W), .PAIR_W(PAIR_W), .SEED_W(SEED_W), .AW(AW)
  ) pack_i (
    .clk(clk), .rst(rst), .phase(phase), .k_q(k_q), .poly(poly),
    .pair(pair), .sub(sub), .seed_idx(seed_idx), .coef_data(coef_data),
    .seed(seed), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  // odd coefficient is fetched for both the middle and the last byte
  assign coef_addr = {poly, pair, (sub != 2'd0)};
  assign busy      = (phase != PH_IDLE);

  // R3: every pack or seed cycle yields a write strobe on the next cycle
  p_write_cadence_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PACK || phase == PH_SEED) |=> wr_en);

  // R3: strobes only follow an active cycle
  p_write_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));

  // R4: second region stays below 384*k
  p_region1_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |-> (wr_addr < AW'(k_q) * AW'(BPP)));

  // R5: first region, seed tail included, stays below 384*k+32
  p_region0_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |-> (wr_addr < AW'(k_q) * AW'(BPP) + AW'(SEED_BYTES)));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done directly follows a write and comes with busy low
  p_done_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_en) && !busy));
endmodule

// File: tb/coef_pack12_tb_top.sv
`timescale 1ns/1ps
module coef_pack12_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [2:0]   k_sel = 3'd2;
  logic [255:0] seed_v = '0;
  logic [10:0]  coef_addr;
  logic [11:0]  coef_data;
  logic         wr_en, wr_sel, busy, done;
  logic [10:0]  wr_addr;
  logic [7:0]   wr_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  coef_pack12 dut_i (
    .clk(clk), .rst(rst), .start(start), .k_sel(k_sel), .seed(seed_v),
    .coef_addr(coef_addr), .coef_data(coef_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  function automatic int coef_f(int p, int i);
    return (p*977 + i*131 + 7) % 3329;
  endfunction

  // combinational coefficient store (R8)
  always @* coef_data = 12'(coef_f(int'(coef_addr[10:8]), int'(coef_addr[7:0])));

  function automatic logic [7:0] exp_byte(int k, int sel, int a, logic [255:0] sd);
    int p, w, n, b, c0, c1;
    if (sel == 0 && a >= 384*k) return sd[(a-384*k)*8 +: 8];
    p  = a/384 + ((sel != 0) ? k : 0);
    w  = a % 384;
    n  = w / 3;
    b  = w % 3;
    c0 = coef_f(p, 2*n);
    c1 = coef_f(p, 2*n+1);
    if (b == 0) return 8'(c0 & 255);
    if (b == 1) return 8'(((c1 & 15) << 4) | (c0 >> 8));
    return 8'(c1 >> 4);
  endfunction

  // write monitor
  logic [7:0] mem0 [0:2047];
  logic [7:0] mem1 [0:2047];
  int cnt0 [0:2047];
  int cnt1 [0:2047];
  int cyc = 0, nwrites = 0, first_w = -1, last_w = -1;
  int last_addr = 0, last_sel = 0;

  always @(negedge clk) begin
    cyc++;
    if (wr_en) begin
      if (wr_sel) begin mem1[wr_addr] = wr_data; cnt1[wr_addr]++; end
      else begin mem0[wr_addr] = wr_data; cnt0[wr_addr]++; end
      nwrites++;
      if (first_w < 0) first_w = cyc;
      last_w = cyc;
      last_addr = int'(wr_addr);
      last_sel = int'(wr_sel);
    end
  end

  task automatic check(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_case(int k);
    int bad_pack, bad_seed, bad_r1, stray, t;
    bit got;
    for (int a = 0; a < 2048; a++) begin cnt0[a] = 0; cnt1[a] = 0; end
    nwrites = 0; first_w = -1; last_w = -1;
    for (int r = 0; r < 32; r++) seed_v[r*8 +: 8] = 8'((r*37 + k*11 + 5) & 255);
    @(negedge clk); #1;
    start = 1'b1; k_sel = 3'(k);
    @(negedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, "R7", int'(busy), 1, "busy after start");
    repeat (100) @(negedge clk);
    #1;
    start = 1'b1; k_sel = (k == 4) ? 3'd2 : 3'd4;   // R6: must be ignored
    @(negedge clk); #1;
    start = 1'b0;
    got = 1'b0;
    for (t = 0; t < 20000; t++) begin
      @(negedge clk); #1;
      if (done) begin got = 1'b1; break; end
    end
    check(got, "R7", 0, 1, "watchdog: done seen");
    if (got) begin
      check(last_w == cyc-1, "R7", cyc-last_w, 1, "done follows last write");
      check(busy == 1'b0, "R7", int'(busy), 0, "busy low with done");
      check(last_addr == 384*k+31 && last_sel == 0, "R5", last_addr, 384*k+31, "final write is seed byte 31");
    end
    check(nwrites == 768*k+32, "R3", nwrites, 768*k+32, "write count (R6 k kept)");
    check(last_w - first_w + 1 == nwrites, "R3", last_w-first_w+1, nwrites, "writes contiguous");
    @(negedge clk); #1;
    check(done == 1'b0, "R7", int'(done), 0, "done one cycle");
    repeat (5) @(negedge clk);
    #1;
    check(busy == 1'b0 && wr_en == 1'b0, "R6", int'(busy), 0, "no second run from ignored start");
    bad_pack = 0; bad_seed = 0; bad_r1 = 0; stray = 0;
    for (int a = 0; a < 384*k; a++) begin
      if (cnt0[a] != 1 || mem0[a] != exp_byte(k, 0, a, seed_v)) begin
        bad_pack++;
        if (bad_pack < 4)
          $display("FAIL R1 region0 addr=%0d actual=%0d expected=%0d", a, mem0[a], exp_byte(k, 0, a, seed_v));
      end
      if (cnt1[a] != 1 || mem1[a] != exp_byte(k, 1, a, seed_v)) begin
        bad_r1++;
        if (bad_r1 < 4)
          $display("FAIL R4 region1 addr=%0d actual=%0d expected=%0d", a, mem1[a], exp_byte(k, 1, a, seed_v));
      end
    end
    for (int r = 0; r < 32; r++) begin
      if (cnt0[384*k+r] != 1 || mem0[384*k+r] != seed_v[r*8 +: 8]) begin
        bad_seed++;
        if (bad_seed < 4)
          $display("FAIL R5 seed byte=%0d actual=%0d expected=%0d", r, mem0[384*k+r], seed_v[r*8 +: 8]);
      end
    end
    for (int a = 0; a < 2048; a++) begin
      if (a >= 384*k+32 && cnt0[a] != 0) stray++;
      if (a >= 384*k && cnt1[a] != 0) stray++;
    end
    check(bad_pack == 0, "R1 R2 R8", bad_pack, 0, "region0 packed byte mismatches");
    check(bad_r1 == 0, "R4", bad_r1, 0, "region1 byte mismatches");
    check(bad_seed == 0, "R5", bad_seed, 0, "seed tail mismatches");
    check(stray == 0, "R4", stray, 0, "writes outside regions");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R9", int'(busy|done|wr_en), 0, "outputs in reset");
    rst = 1'b0;
    @(negedge clk); #1;
    check(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R9", int'(busy|done|wr_en), 0, "idle after reset");
    run_case(2);
    run_case(3);
    run_case(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule